// File: doc/BRIEF.md
# 100BASE-X Receive Delimiter Framer

This block sits between a 100 Mb/s symbol decoder and an MII-style media access controller. It takes in one decoded 5-bit code group per symbol strobe. Each group carries a kind flag that marks it as data, control or invalid. The block finds where a stream begins and ends and drives carrier sense, receive data valid, a 4-bit nibble and a receive error flag. A stream begins with the start delimiter pair, a /J/ immediately followed by a /K/. It ends with the end delimiter pair, a /T/ immediately followed by an /R/. The block also marks coding errors inside a frame, false carriers and streams that collapse into idle without a proper end.

The receive path keeps a one-symbol lookahead, so it can judge a /J/ or /T/ by the symbol that follows it. An accepted symbol is reported one accepted symbol later. The input stream has no back-pressure, because line symbols cannot wait. `sym_valid` is a pure strobe. Every cycle in which it is high consumes one code group. Each consumed code group produces exactly one output beat, marked by `out_valid` in the following cycle. Between beats the receive outputs hold their values.

A small combinational transmit map in the same block converts a transmit nibble into its 5-bit code group. It replaces that code group with the halt group when the MAC requests a transmit error.

Top module: `sdf_framer`

## Requirements
- R1: A /J/ (control kind 01, code 11000) immediately followed by a /K/ (code 10001) starts a frame. The beats for the /J/ and the /K/ both show crs=1, rx_dv=1, rxd=0101, rx_er=0.
- R2: Inside a frame, a /T/ (code 01101) immediately followed by an /R/ (code 00111) ends the frame. Both beats show crs=0, rx_dv=0, rxd=0000, rx_er=0.
- R3: Inside a frame, an /IDLE/ (code 11111) that is not preceded by a /T/R/ pair ends the frame. Its beat shows crs=0, rx_dv=0 and rx_er=1. The error lasts for that single beat.
- R4: Inside a frame, any invalid group produces a beat with crs=1, rx_dv=1, rx_er=1 and rxd=1110. Invalid groups are: kind 10 or 11, a data-kind code that is not one of the 16 data groups, an unknown control code, /H/, /J/, /K/, an /R/ without a /T/, or a /T/ not followed by /R/.
- R5: Inside a frame, a data-kind group produces crs=1, rx_dv=1, rx_er=0 and rxd equal to its 4-bit value. The data groups for values 0 to F are 11110 01001 10100 10101 01010 01011 01110 01111 10010 10011 10110 10111 11010 11011 11100 11101.
- R6: Outside a frame, a /J/ not immediately followed by /K/ is a false carrier. Its beat shows rx_er=1, rxd=1110, crs=0 and rx_dv=0, and the receiver stays out of frame.
- R7: Outside a frame, every group other than a /J/ is ignored. Its beat shows crs=0, rx_dv=0, rx_er=0 and rxd=0000.
- R8: `out_valid` is high in exactly the cycles that follow a cycle with `sym_valid` high. The N-th beat reports the group accepted just before the N-th accepted group. The first beat after reset reports idle.
- R9: `tx_code` is 00100 (/H/) when `tx_en` and `tx_er` are both high. It is the data group of `tx_nib` when only `tx_en` is high, and 11111 when `tx_en` is low.
- R10: While reset is active, crs, rx_dv, rx_er, out_valid and rxd are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | Strobe: a code group is present this cycle |
| sym_code | input | 5 | Decoded 5-bit code group |
| sym_kind | input | 2 | 00 data, 01 control, 10/11 invalid |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rxd | output | 4 | Receive nibble |
| rx_er | output | 1 | Receive error |
| out_valid | output | 1 | A new receive beat is present |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error request |
| tx_nib | input | 4 | Transmit nibble |
| tx_code | output | 5 | Transmit code group |

## Verification
The hardest states to reach are those where two delimiter rules meet. Examples are a stream that collapses into idle immediately followed by a /J/ with no /K/, a doubled /J/ before a real start, and a /T/ followed by idle instead of /R/. Random frame traffic almost never produces these back to back. Directed sequences place them explicitly among random frames, which end cleanly, end abruptly or carry invalid groups. Random gaps in the symbol strobe are added throughout, so the lookahead must survive idle cycles between the two halves of a delimiter pair.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int SYM_W  = 5;
  localparam int NIB_W  = 4;
  localparam int KIND_W = 2;
  localparam int NUM_DATA = 1 << NIB_W;

  localparam logic [KIND_W-1:0] KIND_DATA = 2'b00;
  localparam logic [KIND_W-1:0] KIND_CTRL = 2'b01;

  localparam logic [SYM_W-1:0] CODE_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CODE_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CODE_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CODE_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CODE_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CODE_HALT = 5'b00100;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;
  localparam logic [NIB_W-1:0] ERR_NIB = 4'b1110;

  typedef enum logic [2:0] {
    C_DATA, C_J, C_K, C_T, C_R, C_IDLE, C_BAD, C_HALT
  } sym_cls_e;

  typedef struct packed {
    sym_cls_e         cls;
    logic [NIB_W-1:0] nib;
  } sym_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SSD, ST_DATA, ST_ESD
  } fr_state_e;

  function automatic logic [SYM_W-1:0] enc5(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;  4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;  4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;  4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;  4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;  4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;  4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;  4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;  default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sdf_rx_classify.sv
module sdf_rx_classify
  import sdf_pkg::*;
(
  input  logic [SYM_W-1:0]  code,
  input  logic [KIND_W-1:0] kind,
  output sym_t              sym
);
  always_comb begin
    sym.cls = C_BAD;
    sym.nib = '0;
    if (kind == KIND_DATA) begin
      for (int i = 0; i < NUM_DATA; i++) begin
        if (enc5(i[NIB_W-1:0]) == code) begin
          sym.cls = C_DATA;
          sym.nib = i[NIB_W-1:0];
        end
      end
    end else if (kind == KIND_CTRL) begin
      case (code)
        CODE_J:    sym.cls = C_J;
        CODE_K:    sym.cls = C_K;
        CODE_T:    sym.cls = C_T;
        CODE_R:    sym.cls = C_R;
        CODE_IDLE: sym.cls = C_IDLE;
        CODE_HALT: sym.cls = C_HALT;
        default:   sym.cls = C_BAD;
      endcase
    end
  end
endmodule

// File: rtl/sdf_rx_framer.sv
module sdf_rx_framer
  import sdf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  sym_t             cur,
  output logic             crs,
  output logic             rx_dv,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_er,
  output logic             out_valid
);
  fr_state_e        st, n_st;
  sym_t             hold;
  logic             n_crs, n_dv, n_er;
  logic [NIB_W-1:0] n_rxd;

  always_comb begin
    n_st  = st;
    n_crs = 1'b0;
    n_dv  = 1'b0;
    n_er  = 1'b0;
    n_rxd = '0;
    case (st)
      ST_IDLE: begin
        if (hold.cls == C_J) begin
          if (cur.cls == C_K) begin
            n_crs = 1'b1;
            n_dv  = 1'b1;
            n_rxd = PRE_NIB;
            n_st  = ST_SSD;
          end else begin
            n_er  = 1'b1;
            n_rxd = ERR_NIB;
          end
        end
      end
      ST_SSD: begin
        n_crs = 1'b1;
        n_dv  = 1'b1;
        n_rxd = PRE_NIB;
        n_st  = ST_DATA;
      end
      ST_DATA: begin
        if (hold.cls == C_T && cur.cls == C_R) begin
          n_st = ST_ESD;
        end else if (hold.cls == C_IDLE) begin
          n_er = 1'b1;
          n_st = ST_IDLE;
        end else if (hold.cls == C_DATA) begin
          n_crs = 1'b1;
          n_dv  = 1'b1;
          n_rxd = hold.nib;
        end else begin
          n_crs = 1'b1;
          n_dv  = 1'b1;
          n_er  = 1'b1;
          n_rxd = ERR_NIB;
        end
      end
      default: n_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hold      <= '{cls: C_IDLE, nib: '0};
      crs       <= 1'b0;
      rx_dv     <= 1'b0;
      rx_er     <= 1'b0;
      rxd       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= sym_valid;
      if (sym_valid) begin
        st    <= n_st;
        hold  <= cur;
        crs   <= n_crs;
        rx_dv <= n_dv;
        rx_er <= n_er;
        rxd   <= n_rxd;
      end
    end
  end
endmodule

// File: rtl/sdf_tx_map.sv
module sdf_tx_map
  import sdf_pkg::*;
(
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] tx_nib,
  output logic [SYM_W-1:0] tx_code
);
  always_comb begin
    if (!tx_en)     tx_code = CODE_IDLE;
    else if (tx_er) tx_code = CODE_HALT;
    else            tx_code = enc5(tx_nib);
  end
endmodule

// File: rtl/sdf_framer.sv
module sdf_framer
  import sdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [SYM_W-1:0]  sym_code,
  input  logic [KIND_W-1:0] sym_kind,
  output logic              crs,
  output logic              rx_dv,
  output logic [NIB_W-1:0]  rxd,
  output logic              rx_er,
  output logic              out_valid,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [NIB_W-1:0]  tx_nib,
  output logic [SYM_W-1:0]  tx_code
);
  sym_t cur_sym;

  sdf_rx_classify u_cls (
    .code (sym_code),
    .kind (sym_kind),
    .sym  (cur_sym)
  );

  sdf_rx_framer u_fr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .cur       (cur_sym),
    .crs       (crs),
    .rx_dv     (rx_dv),
    .rxd       (rxd),
    .rx_er     (rx_er),
    .out_valid (out_valid)
  );

  sdf_tx_map u_tx (
    .tx_en   (tx_en),
    .tx_er   (tx_er),
    .tx_nib  (tx_nib),
    .tx_code (tx_code)
  );
endmodule

// File: rtl/sdf_framer_chk.sv
module sdf_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_valid,
  input logic       crs,
  input logic       rx_dv,
  input logic [3:0] rxd,
  input logic       rx_er,
  input logic       out_valid,
  input logic       tx_en,
  input logic       tx_er,
  input logic [4:0] tx_code
);
  // R1/R5: data valid only ever appears together with carrier
  p_dv_has_crs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> crs);

  // R4: an error inside a frame carries the error nibble
  p_err_nib_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && rx_dv) |-> rxd == 4'b1110);

  // R7: with no carrier and no error, the nibble is idle
  p_idle_nib_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!crs && !rx_er) |-> rxd == 4'b0000);

  // R8: one beat per accepted symbol, in the next cycle
  p_beat_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> out_valid);
  p_no_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable({crs, rx_dv, rxd, rx_er}));

  // R9: transmit mapping
  p_tx_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_er) |-> tx_code == 5'b00100);
  p_tx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> tx_code == 5'b11111);

  // R10: reset clears the receive outputs
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |-> !crs && !rx_dv && !rx_er && !out_valid && rxd == 4'b0000);
endmodule

bind sdf_framer sdf_framer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sym_valid (sym_valid),
  .crs       (crs),
  .rx_dv     (rx_dv),
  .rxd       (rxd),
  .rx_er     (rx_er),
  .out_valid (out_valid),
  .tx_en     (tx_en),
  .tx_er     (tx_er),
  .tx_code   (tx_code)
);

// File: tb/sdf_framer_test.sv
module sdf_framer_test;
  localparam int MAXN = 8000;
  localparam int K_DATA = 0, K_J = 1, K_K = 2, K_T = 3, K_R = 4,
                 K_IDLE = 5, K_BAD = 6, K_HALT = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [4:0] sym_code = 5'b11111;
  logic [1:0] sym_kind = 2'b01;
  logic       crs, rx_dv, rx_er, out_valid;
  logic [3:0] rxd;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic [4:0] tx_code;

  int checks = 0, fails = 0;
  int nsym = 0, beats = 0;
  bit done = 1'b0;

  logic [4:0] code_a [MAXN];
  logic [1:0] kind_a [MAXN];
  int         cls_a  [MAXN];
  logic [3:0] nib_a  [MAXN];
  logic [6:0] exp_a  [MAXN];
  string      tag_a  [MAXN];

  always #5 clk = ~clk;

  sdf_framer uut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
    .sym_kind(sym_kind), .crs(crs), .rx_dv(rx_dv), .rxd(rxd), .rx_er(rx_er),
    .out_valid(out_valid), .tx_en(tx_en), .tx_er(tx_er), .tx_nib(tx_nib),
    .tx_code(tx_code)
  );

  function automatic logic [4:0] tb_enc(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic push(input logic [4:0] c, input logic [1:0] k, input int cl, input logic [3:0] n);
    if (nsym < MAXN) begin
      code_a[nsym] = c; kind_a[nsym] = k; cls_a[nsym] = cl; nib_a[nsym] = n;
      nsym++;
    end
  endtask
  task automatic pdat(input logic [3:0] n); push(tb_enc(n), 2'b00, K_DATA, n); endtask
  task automatic pctl(input logic [4:0] c, input int cl); push(c, 2'b01, cl, 4'h0); endtask
  task automatic pidle(input int n); for (int i = 0; i < n; i++) pctl(5'b11111, K_IDLE); endtask
  task automatic pstart();
    pctl(5'b11000, K_J); pctl(5'b10001, K_K);
    for (int i = 0; i < 6; i++) pdat(4'h5);
    pdat(4'hD);
  endtask
  task automatic pbad();
    case ($urandom_range(3))
      0: push(5'b01010, 2'b10, K_BAD, 4'h0);
      1: push(5'b00000, 2'b00, K_BAD, 4'h0);
      2: pctl(5'b00100, K_HALT);
      default: push(5'b11110, 2'b11, K_BAD, 4'h0);
    endcase
  endtask

  // ending: 0 clean /T/R/, 1 abrupt idle, 2 invalid group inside then clean
  task automatic gen_frame(input int ending);
    int len = $urandom_range(4, 20);
    pidle($urandom_range(1, 4));
    pstart();
    for (int i = 0; i < len; i++) begin
      if (ending == 2 && i == len / 2) pbad();
      pdat(4'($urandom_range(15)));
    end
    if (ending == 1) pidle(1);
    else begin pctl(5'b01101, K_T); pctl(5'b00111, K_R); end
    pidle($urandom_range(1, 3));
  endtask

  // Expected beats derived from the requirements
  task automatic build_expected();
    int st = 0; int hc = K_IDLE; logic [3:0] hn = 4'h0;
    for (int n = 0; n < nsym; n++) begin
      int c = cls_a[n];
      logic [6:0] e = 7'b0;   // {crs, dv, rxd, er}
      string t = "R7";
      case (st)
        0: if (hc == K_J && c == K_K) begin e = {2'b11, 4'b0101, 1'b0}; t = "R1"; st = 1; end
           else if (hc == K_J) begin e = {2'b00, 4'b1110, 1'b1}; t = "R6"; end
        1: begin e = {2'b11, 4'b0101, 1'b0}; t = "R1"; st = 2; end
        2: if (hc == K_T && c == K_R) begin t = "R2"; st = 3; end
           else if (hc == K_IDLE) begin e = {2'b00, 4'b0000, 1'b1}; t = "R3"; st = 0; end
           else if (hc == K_DATA) begin e = {2'b11, hn, 1'b0}; t = "R5"; end
           else begin e = {2'b11, 4'b1110, 1'b1}; t = "R4"; end
        default: begin t = "R2"; st = 0; end
      endcase
      exp_a[n] = e; tag_a[n] = t;
      hc = c; hn = nib_a[n];
    end
  endtask

  // Monitor: beat content and beat cadence (R8)
  initial begin
    logic last_sv = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #1;
      if (done) break;
      check("R8 cadence", out_valid, last_sv);
      if (out_valid) begin
        if (beats < nsym)
          check(tag_a[beats], {crs, rx_dv, rxd, rx_er}, exp_a[beats]);
        beats++;
      end
      last_sv = sym_valid;
    end
  end

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // Directed corner cases
    pidle(2);
    pdat(4'h3); pctl(5'b01101, K_T); pctl(5'b00111, K_R); pctl(5'b10001, K_K);
    pctl(5'b00100, K_HALT); push(5'b00000, 2'b10, K_BAD, 4'h0);       // R7 junk
    pctl(5'b11000, K_J); pctl(5'b11111, K_IDLE);                       // R6 false carrier
    pctl(5'b11000, K_J); pstart(); pdat(4'hA);                          // J J K
    pctl(5'b01101, K_T); pidle(1);                                      // T then idle
    pstart(); pdat(4'h1); pidle(1); pctl(5'b11000, K_J); pdat(4'h2);   // abrupt end, then false J
    pstart(); pctl(5'b00111, K_R); pctl(5'b11000, K_J); pctl(5'b10001, K_K);
    pctl(5'b01101, K_T); pctl(5'b00111, K_R); pidle(2);
    for (int f = 0; f < 150; f++) gen_frame($urandom_range(2));
    build_expected();

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 reset", {crs, rx_dv, rxd, rx_er, out_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {crs, rx_dv, rxd, rx_er, out_valid}, 8'h00);

    for (int n = 0; n < nsym; n++) begin
      while ($urandom_range(3) == 0) begin
        sym_valid = 1'b0;
        sym_code = 5'($urandom);
        @(negedge clk);
      end
      sym_valid = 1'b1;
      sym_code = code_a[n];
      sym_kind = kind_a[n];
      @(negedge clk);
    end
    sym_valid = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    #2;
    check("R8 beat count", beats, nsym);

    // R9: transmit map
    for (int i = 0; i < 64; i++) begin
      logic [4:0] e;
      tx_en  = (i < 16) ? 1'b1 : ($urandom_range(3) != 0);
      tx_er  = (i < 16) ? 1'b0 : 1'($urandom);
      tx_nib = (i < 16) ? 4'(i) : 4'($urandom);
      e = !tx_en ? 5'b11111 : (tx_er ? 5'b00100 : tb_enc(tx_nib));
      #3;
      check("R9 tx map", tx_code, e);
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule